// File: doc/BRIEF.md
# LFSR Periodic Sync Pulse Generator

This block stands in for an absent once-per-second timing input in a link pattern tester. It runs a linear feedback shift register made of ordinary flip-flops. The register steps through every non-zero state and then repeats. Once in each repeat the block raises a sync pulse that lasts one clock. The downstream pattern generator uses that pulse as its frame marker. The exact period does not matter as long as it is long enough, at roughly ten thousand clocks or more. With the default 14-bit register the period is 16383 clocks.

A full-width binary compare would limit the clock rate, so the block offers three pulse sources, chosen by parameter:

- **All-ones detection.** The register is split into groups of four bits. Each group is ANDed and the results are registered. The group results are then combined in a second stage.
- **Run-length detection.** A small counter watches the serial output bit and recognises the single longest run of zeros in each period.
- **Prescaled count.** A short fast counter produces a carry, and the carry enables a longer, slower counter. This mode ignores the register contents.

The detection latency is fixed in every mode, so the pulses stay evenly spaced. An enable input freezes the whole block.

Top module: `lfsr_sync_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the register loads the seed: only bit W-1 set, all other bits 0. At the same edge `sync_o` goes to 0 and all detector and counter state clears.
- R2: At each clock edge with `en` high, `state_o` becomes `{^(state_o & TAP_MASK), state_o[W-1:1]}`. That is, the register shifts toward bit 0 and the XOR of the masked bits enters bit W-1. Bit 0 is the serial output.
- R3: `state_o` is never all zeros.
- R4: In all-ones mode, `sync_o` is high in exactly those cycles that follow an enabled edge and in which `state_o` holds the state two enabled steps after the all-ones state. This gives a fixed two-stage latency.
- R5: With a maximal-length mask, successive pulses in all-ones mode are exactly 2^W-1 enabled clocks apart. For the default W=14 this is 16383.
- R6: In run-length mode, count n enabled edges from reset. `sync_o` is high after enabled edge n exactly when n ≥ W-1 and (n-(W-1)) is a multiple of 2^W-1. This happens once the serial bit has been 0 for W-1 consecutive enabled edges.
- R7: In prescaled mode, `sync_o` is high after enabled edge n exactly when n > 0 and n is a multiple of PRE_DIV*MAIN_DIV.
- R8: At an edge with `en` low, `state_o` and all counters hold their values, and `sync_o` is 0 in the following cycle.
- R9: `sync_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Advance enable; when low, the block holds its state |
| sync_o | output | 1 | Registered one-clock sync pulse |
| state_o | output | W | Current LFSR state; bit 0 is the serial output |

## Verification
A wrong tap or shift shows on `state_o` within one enabled clock. Such a fault also moves or removes the all-ones state, so the next pulse arrives at the wrong place or never arrives. An off-by-one in a detector stage or in a counter terminal value shifts the first pulse by one cycle. It then repeats the error on every later period. A comparison against the computed pulse index therefore catches it within one period of reset. An enable that leaks into a single register lets that register drift away from the LFSR state. The mismatch appears in the first disabled cycle, or one period later as a change in pulse spacing.

// File: rtl/lfsr_sync_pkg.sv
// Shared types for the LFSR sync pulse generator.
package lfsr_sync_pkg;

    // Selects which circuit produces the sync pulse.
    typedef enum logic [1:0] {
        DET_ALL_ONES   = 2'd0,
        DET_RUN_LENGTH = 2'd1,
        DET_PRESCALE   = 2'd2
    } det_mode_e;

endpackage

// File: rtl/lfsr_sync_shift.sv
// LFSR register built from ordinary flip-flops.
// Shifts toward bit 0 on every enabled clock. The XOR of the bits selected
// by TAP_MASK enters bit W-1.
// Assumes TAP_MASK includes bit 0, which makes the recurrence degree W.
// Reset loads a single 1 in the MSB, so the all-zero state is never reached.
module lfsr_sync_shift #(
    parameter int             W        = 14,
    parameter logic [W-1:0]   TAP_MASK = W'(14'h2A01)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    output logic [W-1:0] state
);

    localparam logic [W-1:0] SEED = {1'b1, {(W-1){1'b0}}};

    logic feedback;

    // Parity of the tapped bits forms the new MSB.
    always_comb feedback = ^(state & TAP_MASK);

    // Advance the register on enable; load the seed on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEED;
        end else if (en) begin
            state <= {feedback, state[W-1:1]};
        end
    end

endmodule

// File: rtl/lfsr_sync_ones.sv
// Pipelined all-ones detector.
// Stage 1 registers the AND of each group of four state bits. Bits beyond W
// are padded with ones. Stage 2 registers the AND of the group results as
// the sync pulse.
// The latency is fixed at two enabled clocks.
// Both stages hold while en is low, and the pulse is cleared at any disabled
// edge.
module lfsr_sync_ones #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] state,
    output logic         pulse
);

    localparam int GROUPS = (W + 3) / 4;
    localparam int PADW   = GROUPS * 4;

    logic [PADW-1:0]   padded;
    logic [GROUPS-1:0] grp_and;
    logic [GROUPS-1:0] grp_q;

    // Extend the state to a whole number of groups, filling with ones.
    always_comb begin
        padded         = '1;
        padded[W-1:0]  = state;
    end

    // One four-input AND per group.
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        assign grp_and[g] = &padded[4*g +: 4];
    end

    // Stage 1: capture the group results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_q <= '0;
        end else if (en) begin
            grp_q <= grp_and;
        end
    end

    // Stage 2: combine the groups into the registered pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse <= 1'b0;
        end else begin
            pulse <= en && (&grp_q);
        end
    end

endmodule

// File: rtl/lfsr_sync_runlen.sv
// Run-length detector on the serial output bit.
// The counter clears when the bit is 1 and counts up when it is 0.
// A maximal-length sequence has exactly one run of W-1 zeros per period, so
// reaching W-1 marks one fixed point in the sequence. That point lies W-1
// steps after the seed state.
// Only the serial bit is used, so no wide decode is needed.
// Assumes W >= 3.
module lfsr_sync_runlen #(
    parameter int W = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic serial,
    output logic pulse
);

    localparam int            CW      = $clog2(W);
    localparam logic [CW-1:0] CNT_TOP = CW'(W - 1);
    localparam logic [CW-1:0] CNT_PRE = CW'(W - 2);

    logic [CW-1:0] zero_run;

    // Track the length of the current run of zeros, saturating at W-1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zero_run <= '0;
        end else if (en) begin
            if (serial) begin
                zero_run <= '0;
            end else if (zero_run != CNT_TOP) begin
                zero_run <= zero_run + CW'(1);
            end
        end
    end

    // Raise the pulse on the edge at which the run reaches W-1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse <= 1'b0;
        end else begin
            pulse <= en && !serial && (zero_run == CNT_PRE);
        end
    end

endmodule

// File: rtl/lfsr_sync_prescale.sv
// Prescaled period counter.
// A short counter wraps every PRE_DIV enabled clocks. Its carry enables a
// long counter that wraps every MAIN_DIV carries. Only the short counter has
// to meet full clock rate.
// The pulse marks the edge at which both counters wrap together.
// Assumes PRE_DIV >= 2 and MAIN_DIV >= 2.
module lfsr_sync_prescale #(
    parameter int PRE_DIV  = 16,
    parameter int MAIN_DIV = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic pulse
);

    localparam int            LW      = $clog2(PRE_DIV);
    localparam int            HW      = $clog2(MAIN_DIV);
    localparam logic [LW-1:0] LOW_TOP = LW'(PRE_DIV - 1);
    localparam logic [HW-1:0] HI_TOP  = HW'(MAIN_DIV - 1);

    logic [LW-1:0] low_cnt;
    logic [HW-1:0] hi_cnt;
    logic          carry;

    // Carry out of the fast counter.
    always_comb carry = (low_cnt == LOW_TOP);

    // Fast counter, modulo PRE_DIV.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (en) begin
            low_cnt <= carry ? '0 : low_cnt + LW'(1);
        end
    end

    // Slow counter, modulo MAIN_DIV, stepped only by the carry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= '0;
        end else if (en && carry) begin
            hi_cnt <= (hi_cnt == HI_TOP) ? '0 : hi_cnt + HW'(1);
        end
    end

    // Pulse when both counters wrap on the same enabled edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse <= 1'b0;
        end else begin
            pulse <= en && carry && (hi_cnt == HI_TOP);
        end
    end

endmodule

// File: rtl/lfsr_sync_gen.sv
// LFSR periodic sync pulse generator, top level.
// Instantiates the LFSR register and one pulse source, chosen by MODE.
// The source's registered pulse drives sync_o directly.
// Assumes TAP_MASK gives a maximal-length sequence for width W.
module lfsr_sync_gen #(
    parameter int                       W        = 14,
    parameter logic [W-1:0]             TAP_MASK = W'(14'h2A01),
    parameter lfsr_sync_pkg::det_mode_e MODE     = lfsr_sync_pkg::DET_ALL_ONES,
    parameter int                       PRE_DIV  = 16,
    parameter int                       MAIN_DIV = 1024
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    output logic         sync_o,
    output logic [W-1:0] state_o
);

    logic [W-1:0] lfsr_q;
    logic         det_pulse;

    lfsr_sync_shift #(
        .W        (W),
        .TAP_MASK (TAP_MASK)
    ) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .state (lfsr_q)
    );

    if (MODE == lfsr_sync_pkg::DET_ALL_ONES) begin : g_ones
        lfsr_sync_ones #(.W(W)) u_det (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en),
            .state (lfsr_q),
            .pulse (det_pulse)
        );
    end else if (MODE == lfsr_sync_pkg::DET_RUN_LENGTH) begin : g_run
        lfsr_sync_runlen #(.W(W)) u_det (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (en),
            .serial (lfsr_q[0]),
            .pulse  (det_pulse)
        );
    end else begin : g_pre
        lfsr_sync_prescale #(
            .PRE_DIV  (PRE_DIV),
            .MAIN_DIV (MAIN_DIV)
        ) u_det (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en),
            .pulse (det_pulse)
        );
    end

    assign sync_o  = det_pulse;
    assign state_o = lfsr_q;

endmodule

// File: rtl/lfsr_sync_gen_chk.sv
// Port-level property checker for lfsr_sync_gen. It is bound to every
// instance of the top module.
module lfsr_sync_gen_chk #(
    parameter int W = 14
) (
    input logic         clk,
    input logic         rst_n,
    input logic         en,
    input logic         sync_o,
    input logic [W-1:0] state_o
);

    // R1
    seed_load_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (state_o == {1'b1, {(W-1){1'b0}}}) && !sync_o);

    // R2
    shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> state_o[W-2:0] == $past(state_o[W-1:1]));

    // R3
    nonzero_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_o != '0);

    // R8
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(state_o) && !sync_o);

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_o |=> !sync_o);

endmodule

bind lfsr_sync_gen lfsr_sync_gen_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .sync_o  (sync_o),
    .state_o (state_o)
);

// File: tb/lfsr_sync_gen_test.sv
module lfsr_sync_gen_test;
    import lfsr_sync_pkg::*;

    localparam int             SW    = 5;
    localparam logic [SW-1:0]  SMASK = 5'b00101;
    localparam int             SPER  = 31;
    localparam int             BPER  = 16383;
    localparam int             PRE   = 4;
    localparam int             MAIN  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    always #4 clk = ~clk;

    logic          s_ones, s_rl, s_ps, s_big;
    logic [SW-1:0] st_ones, st_rl, st_ps;
    logic [13:0]   st_big;

    lfsr_sync_gen #(.W(SW), .TAP_MASK(SMASK), .MODE(DET_ALL_ONES)) uut (
        .clk(clk), .rst_n(rst_n), .en(en), .sync_o(s_ones), .state_o(st_ones));
    lfsr_sync_gen #(.W(SW), .TAP_MASK(SMASK), .MODE(DET_RUN_LENGTH)) uut_rl (
        .clk(clk), .rst_n(rst_n), .en(en), .sync_o(s_rl), .state_o(st_rl));
    lfsr_sync_gen #(.W(SW), .TAP_MASK(SMASK), .MODE(DET_PRESCALE),
                    .PRE_DIV(PRE), .MAIN_DIV(MAIN)) uut_ps (
        .clk(clk), .rst_n(rst_n), .en(en), .sync_o(s_ps), .state_o(st_ps));
    lfsr_sync_gen uut_big (
        .clk(clk), .rst_n(rst_n), .en(en), .sync_o(s_big), .state_o(st_big));

    int            checks = 0;
    int            fails = 0;
    logic [SW-1:0] ref_s, h1, h2;
    int            nv, ones_last, big_last, big_cnt;
    bit            last_en, big_prev;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // R2 recurrence, written from the requirement.
    function automatic logic [SW-1:0] adv(input logic [SW-1:0] s);
        return {^(s & SMASK), s[SW-1:1]};
    endfunction

    task automatic model_reset();
        ref_s = 5'b10000; h1 = '0; h2 = '0; nv = 0; last_en = 1'b0;
        ones_last = -1; big_last = -1; big_prev = 1'b0; big_cnt = 0;
    endtask

    task automatic observe();
        bit e_ones, e_rl, e_ps;
        chk("R2 state all-ones uut", 32'(st_ones), 32'(ref_s));
        chk("R2 state run-length uut", 32'(st_rl), 32'(ref_s));
        chk("R2 state prescale uut", 32'(st_ps), 32'(ref_s));
        chk("R3 state nonzero", 32'((st_ones != 0) && (st_big != 0)), 32'd1);
        e_ones = last_en && (nv >= 2) && (h2 == 5'b11111);
        chk("R4 all-ones pulse", 32'(s_ones), 32'(e_ones));
        e_rl = last_en && (nv >= SW-1) && (((nv - (SW-1)) % SPER) == 0);
        chk("R6 run-length pulse", 32'(s_rl), 32'(e_rl));
        e_ps = last_en && (nv > 0) && ((nv % (PRE*MAIN)) == 0);
        chk("R7 prescale pulse", 32'(s_ps), 32'(e_ps));
        if (!last_en)
            chk("R8 no pulse after disabled edge", 32'(s_ones | s_rl | s_ps | s_big), 32'd0);
        if (s_ones) begin
            if (ones_last >= 0) chk("R5 small spacing", 32'(nv - ones_last), 32'(SPER));
            ones_last = nv;
        end
        if (s_big) begin
            chk("R9 big pulse width", 32'(big_prev), 32'd0);
            if (big_last >= 0) chk("R5 default spacing", 32'(nv - big_last), 32'(BPER));
            big_last = nv;
            big_cnt++;
        end
        big_prev = s_big;
    endtask

    task automatic step(input logic e);
        en = e;
        @(posedge clk);
        if (e) begin
            h2 = h1; h1 = ref_s; ref_s = adv(ref_s); nv++;
        end
        last_en = e;
        @(negedge clk);
        observe();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        en = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        chk("R1 seed small", 32'(st_ones ^ st_rl ^ st_ps), 32'(5'b10000));
        chk("R1 seed default", 32'(st_big), 32'(14'h2000));
        chk("R1 pulses low in reset", 32'(s_ones | s_rl | s_ps | s_big), 32'd0);
        rst_n = 1'b1;
        model_reset();
    endtask

    initial begin
        model_reset();
        do_reset();
        for (int i = 0; i < 120; i++) step(((i % 7) != 3) && ((i % 11) != 5));
        for (int i = 0; i < 100; i++) step(1'b1);
        for (int i = 0; i < 6; i++) step(1'b0);
        do_reset();
        for (int i = 0; i < 2*BPER + 40; i++) step(1'b1);
        chk("R5 default pulses seen", 32'(big_cnt >= 2), 32'd1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R5: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule